// File: doc/BRIEF.md
# Two's-Complement Add/Subtract Unit with Comparison Decode

This block is a purely combinational arithmetic unit for two N-bit operands (N defaults to 32). One control input chooses between A+B and A−B. A single carry-propagate adder serves both operations: for subtraction the B operand is inverted bit by bit and the adder carry-in is forced to one. The unit returns the N-bit result together with four condition flags: zero, negative, carry-out and signed overflow.

The same flags are also decoded into ten comparison predicates, six signed and four unsigned. They are meaningful when the unit performs A−B, so a datapath can compare two operands in one pass. A second control input switches the result between modulo-2^N wrap-around and saturation. In saturation, an overflowed result is clamped to the largest or smallest representable signed value. The flags always describe the raw, unclamped arithmetic, so the comparisons stay valid in both modes.

Top module: `addsub_unit`

## Requirements
- R1: With sub_sel=0 and no saturation substitution, result equals (a_in + b_in) mod 2^N.
- R2: With sub_sel=1 and no saturation substitution, result equals (a_in + ~b_in + 1) mod 2^N, which is a_in − b_in modulo 2^N.
- R3: flag_z is 1 exactly when the raw N-bit sum is all zeros.
- R4: flag_n equals bit N−1 of the raw N-bit sum.
- R5: flag_c is the carry out of bit N−1 of the adder, including the forced carry-in of one during subtraction.
- R6: flag_v is 1 exactly when the exact signed result of the selected operation lies outside [−2^(N−1), 2^(N−1)−1].
- R7: The signed predicates are decoded as cmp_lt = N^V, cmp_le = Z|(N^V), cmp_eq = Z, cmp_ne = ~Z, cmp_ge = ~(N^V) and cmp_gt = ~(Z|(N^V)). With sub_sel=1, each one equals the true signed comparison of a_in with b_in.
- R8: The unsigned predicates are decoded as cmp_ltu = ~C, cmp_leu = ~C|Z, cmp_geu = C and cmp_gtu = C&~Z. With sub_sel=1, each one equals the true unsigned comparison of a_in with b_in.
- R9: With sat_sel=1 and a positive overflow, meaning an exact result above 2^(N−1)−1, result is 0 followed by N−1 ones.
- R10: With sat_sel=1 and a negative overflow, meaning an exact result below −2^(N−1), result is 1 followed by N−1 zeros.
- R11: When no overflow occurs, sat_sel has no effect on result. When sat_sel=0, result is always the wrapped sum.
- R12: The four flags and the ten predicates are identical for sat_sel=0 and sat_sel=1 with the same operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| sub_sel | input | 1 | 1 selects a_in − b_in, 0 selects a_in + b_in |
| sat_sel | input | 1 | 1 clamps overflowed results, 0 wraps |
| result | output | N | Wrapped or clamped result |
| flag_z | output | 1 | Raw sum is zero |
| flag_n | output | 1 | Raw sum MSB |
| flag_c | output | 1 | Adder carry out of MSB |
| flag_v | output | 1 | Signed overflow |
| cmp_lt | output | 1 | Signed less-than |
| cmp_le | output | 1 | Signed less-or-equal |
| cmp_eq | output | 1 | Equal |
| cmp_ne | output | 1 | Not equal |
| cmp_ge | output | 1 | Signed greater-or-equal |
| cmp_gt | output | 1 | Signed greater-than |
| cmp_ltu | output | 1 | Unsigned less-than |
| cmp_leu | output | 1 | Unsigned less-or-equal |
| cmp_geu | output | 1 | Unsigned greater-or-equal |
| cmp_gtu | output | 1 | Unsigned greater-than |

## Verification
The bench builds three copies of the block: N=4, N=8 and the default N=32. At N=4 and N=8 every operand pair is applied in both operations and both result modes. That sweep reaches every overflow direction, every saturation clamp, and the most negative operand in every role. The N=32 copy receives directed corners: 0x7FFFFFFF plus one, the most negative value minus one, and subtraction of the most negative value from itself. These confirm that the carry chain and the clamp constants scale to the full width.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef struct packed {
    logic lt;
    logic le;
    logic eq;
    logic ne;
    logic ge;
    logic gt;
    logic ltu;
    logic leu;
    logic geu;
    logic gtu;
  } cmp_t;

  // Signed and unsigned relations implied by the flags of A-B.
  function automatic cmp_t decode_cmp(input logic z, input logic n,
                                      input logic c, input logic v);
    cmp_t r;
    logic less;
    less  = n ^ v;
    r.lt  = less;
    r.le  = z | less;
    r.eq  = z;
    r.ne  = ~z;
    r.ge  = ~less;
    r.gt  = ~(z | less);
    r.ltu = ~c;
    r.leu = ~c | z;
    r.geu = c;
    r.gtu = ~(~c | z);
    return r;
  endfunction

endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             do_sub,
  output logic [WIDTH-1:0] raw_sum,
  output logic             b_eff_msb,
  output logic             carry_into_msb,
  output logic             carry_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] gen;
  logic [WIDTH:0]   chain;

  // Per-bit operand conditioning and propagate/generate terms.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign b_eff[i] = opb[i] ^ do_sub;
    assign prop[i]  = opa[i] ^ b_eff[i];
    assign gen[i]   = opa[i] & b_eff[i];
  end

  function automatic logic [WIDTH:0] ripple(input logic [WIDTH-1:0] p,
                                            input logic [WIDTH-1:0] g,
                                            input logic cin);
    logic [WIDTH:0] cc;
    cc[0] = cin;
    for (int k = 0; k < WIDTH; k++) begin
      cc[k+1] = g[k] | (p[k] & cc[k]);
    end
    return cc;
  endfunction

  always_comb chain = ripple(prop, gen, do_sub);

  assign raw_sum        = prop ^ chain[WIDTH-1:0];
  assign b_eff_msb      = b_eff[MSB];
  assign carry_into_msb = chain[MSB];
  assign carry_out      = chain[WIDTH];

  always_comb begin
    if (!$isunknown({opa, opb, do_sub})) begin
      AST_CARRY_CHAIN: assert ({carry_out, raw_sum} ==
                               ({1'b0, opa} + {1'b0, b_eff} + {{WIDTH{1'b0}}, do_sub})); // R1, R2
    end
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] raw_sum,
  input  logic             a_msb,
  input  logic             b_eff_msb,
  input  logic             carry_into_msb,
  input  logic             carry_out,
  output logic             z,
  output logic             n,
  output logic             c,
  output logic             v
);
  localparam int MSB = WIDTH - 1;

  assign z = ~|raw_sum;
  assign n = raw_sum[MSB];
  assign c = carry_out;
  assign v = carry_into_msb ^ carry_out;

  always_comb begin
    if (!$isunknown({raw_sum, a_msb, b_eff_msb, carry_into_msb, carry_out})) begin
      AST_OVF_FOUR_XOR: assert (v == (a_msb ^ b_eff_msb ^ raw_sum[MSB] ^ carry_out)); // R6
      AST_OVF_SAME_SIGN: assert (!v || (a_msb == b_eff_msb && raw_sum[MSB] != a_msb)); // R6
      AST_ZERO_NONNEG: assert (!z || !n); // R3
    end
  end
endmodule

// File: rtl/addsub_cmp.sv
module addsub_cmp
  import addsub_pkg::*;
(
  input  logic z,
  input  logic n,
  input  logic c,
  input  logic v,
  input  logic is_sub,
  output cmp_t rel
);
  always_comb rel = decode_cmp(z, n, c, v);

  always_comb begin
    if (!$isunknown({z, n, c, v, is_sub}) && is_sub) begin
      AST_SIGNED_TRICHOTOMY: assert ($onehot({rel.lt, rel.eq, rel.gt})); // R7
      AST_UNSIGNED_TRICHOTOMY: assert ($onehot({rel.ltu, rel.eq, rel.gtu})); // R8
      AST_EQ_CARRY: assert (!rel.eq || rel.geu); // R8
    end
  end
endmodule

// File: rtl/addsub_sat.sv
module addsub_sat #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] raw_sum,
  input  logic             ovf,
  input  logic             clamp_en,
  output logic [WIDTH-1:0] res
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] POS_LIMIT = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_LIMIT = {1'b1, {(WIDTH-1){1'b0}}};

  // An overflowed raw sum has the wrong sign: a negative-looking sum
  // means the true value went past the positive limit.
  function automatic logic [WIDTH-1:0] clamp(input logic [WIDTH-1:0] s,
                                             input logic o, input logic en);
    if (en && o) return s[MSB] ? POS_LIMIT : NEG_LIMIT;
    return s;
  endfunction

  always_comb res = clamp(raw_sum, ovf, clamp_en);

  always_comb begin
    if (!$isunknown({raw_sum, ovf, clamp_en})) begin
      AST_PASS_THROUGH: assert ((clamp_en && ovf) || res == raw_sum); // R11
      AST_CLAMP_POS: assert (!(clamp_en && ovf && raw_sum[MSB]) || res == POS_LIMIT); // R9
      AST_CLAMP_NEG: assert (!(clamp_en && ovf && !raw_sum[MSB]) || res == NEG_LIMIT); // R10
    end
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             sub_sel,
  input  logic             sat_sel,
  output logic [WIDTH-1:0] result,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_c,
  output logic             flag_v,
  output logic             cmp_lt,
  output logic             cmp_le,
  output logic             cmp_eq,
  output logic             cmp_ne,
  output logic             cmp_ge,
  output logic             cmp_gt,
  output logic             cmp_ltu,
  output logic             cmp_leu,
  output logic             cmp_geu,
  output logic             cmp_gtu
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] raw_sum;
  logic             b_eff_msb;
  logic             carry_into_msb;
  logic             carry_out;
  cmp_t             rel;

  addsub_core #(.WIDTH(WIDTH)) u_core (
    .opa           (a_in),
    .opb           (b_in),
    .do_sub        (sub_sel),
    .raw_sum       (raw_sum),
    .b_eff_msb     (b_eff_msb),
    .carry_into_msb(carry_into_msb),
    .carry_out     (carry_out)
  );

  addsub_flags #(.WIDTH(WIDTH)) u_flags (
    .raw_sum       (raw_sum),
    .a_msb         (a_in[MSB]),
    .b_eff_msb     (b_eff_msb),
    .carry_into_msb(carry_into_msb),
    .carry_out     (carry_out),
    .z             (flag_z),
    .n             (flag_n),
    .c             (flag_c),
    .v             (flag_v)
  );

  addsub_cmp u_cmp (
    .z     (flag_z),
    .n     (flag_n),
    .c     (flag_c),
    .v     (flag_v),
    .is_sub(sub_sel),
    .rel   (rel)
  );

  addsub_sat #(.WIDTH(WIDTH)) u_sat (
    .raw_sum (raw_sum),
    .ovf     (flag_v),
    .clamp_en(sat_sel),
    .res     (result)
  );

  assign cmp_lt  = rel.lt;
  assign cmp_le  = rel.le;
  assign cmp_eq  = rel.eq;
  assign cmp_ne  = rel.ne;
  assign cmp_ge  = rel.ge;
  assign cmp_gt  = rel.gt;
  assign cmp_ltu = rel.ltu;
  assign cmp_leu = rel.leu;
  assign cmp_geu = rel.geu;
  assign cmp_gtu = rel.gtu;

  always_comb begin
    if (!$isunknown({a_in, b_in, sub_sel, sat_sel})) begin
      AST_FLAGS_FROM_RAW: assert (flag_n == raw_sum[MSB]); // R4, R12
      AST_WRAP_MODE: assert (sat_sel || result == raw_sum); // R11
    end
  end
endmodule

// File: tb/addsub_unit_test.sv
`timescale 1ns/100ps
module addsub_unit_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int n_vec  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // Narrow instance, N=4
  logic [3:0] a4, b4, r4;
  logic s4, t4;
  logic [13:0] f4;
  addsub_unit #(.WIDTH(4)) uut (
    .a_in(a4), .b_in(b4), .sub_sel(s4), .sat_sel(t4), .result(r4),
    .flag_z(f4[13]), .flag_n(f4[12]), .flag_c(f4[11]), .flag_v(f4[10]),
    .cmp_lt(f4[9]), .cmp_le(f4[8]), .cmp_eq(f4[7]), .cmp_ne(f4[6]),
    .cmp_ge(f4[5]), .cmp_gt(f4[4]), .cmp_ltu(f4[3]), .cmp_leu(f4[2]),
    .cmp_geu(f4[1]), .cmp_gtu(f4[0]));

  // Medium instance, N=8
  logic [7:0] a8, b8, r8;
  logic s8, t8;
  logic [13:0] f8;
  addsub_unit #(.WIDTH(8)) uut_w8 (
    .a_in(a8), .b_in(b8), .sub_sel(s8), .sat_sel(t8), .result(r8),
    .flag_z(f8[13]), .flag_n(f8[12]), .flag_c(f8[11]), .flag_v(f8[10]),
    .cmp_lt(f8[9]), .cmp_le(f8[8]), .cmp_eq(f8[7]), .cmp_ne(f8[6]),
    .cmp_ge(f8[5]), .cmp_gt(f8[4]), .cmp_ltu(f8[3]), .cmp_leu(f8[2]),
    .cmp_geu(f8[1]), .cmp_gtu(f8[0]));

  // Default-width instance, N=32
  logic [31:0] a32, b32, r32;
  logic s32, t32;
  logic [13:0] f32;
  addsub_unit uut_w32 (
    .a_in(a32), .b_in(b32), .sub_sel(s32), .sat_sel(t32), .result(r32),
    .flag_z(f32[13]), .flag_n(f32[12]), .flag_c(f32[11]), .flag_v(f32[10]),
    .cmp_lt(f32[9]), .cmp_le(f32[8]), .cmp_eq(f32[7]), .cmp_ne(f32[6]),
    .cmp_ge(f32[5]), .cmp_gt(f32[4]), .cmp_ltu(f32[3]), .cmp_leu(f32[2]),
    .cmp_geu(f32[1]), .cmp_gtu(f32[0]));

  task automatic judge(input int w, input longint unsigned a, input longint unsigned b,
                       input bit sub, input bit sat,
                       input longint unsigned got_r, input logic [13:0] got_f);
    longint unsigned mask, half, beff, tot, sum, exp_r;
    longint sa, sb, ex, maxv, minv;
    bit z, n, c, v;
    logic [13:0] exp_f;
    string rtag, ftag;
    string names [14];
    names = '{"gtu", "geu", "leu", "ltu", "gt", "ge", "ne", "eq", "le", "lt",
              "V", "C", "N", "Z"};
    mask = (64'd1 << w) - 1;
    half = 64'd1 << (w - 1);
    beff = sub ? (~b & mask) : b;
    tot  = a + beff + (sub ? 1 : 0);
    sum  = tot & mask;
    c    = ((tot >> w) & 1) != 0;
    sa   = (a >= half) ? longint'(a) - longint'(2 * half) : longint'(a);
    sb   = (b >= half) ? longint'(b) - longint'(2 * half) : longint'(b);
    ex   = sub ? sa - sb : sa + sb;
    maxv = longint'(half) - 1;
    minv = -longint'(half);
    v    = (ex > maxv) || (ex < minv);
    z    = (sum == 0);
    n    = ((sum >> (w - 1)) & 1) != 0;
    if (sat && v) exp_r = (ex > maxv) ? longint'(maxv) : (longint'(minv) & mask);
    else          exp_r = sum;
    exp_f[13:10] = {z, n, c, v};
    if (sub) begin
      // R7, R8: true relations of the operands
      exp_f[9:0] = {sa < sb, sa <= sb, a == b, a != b, sa >= sb, sa > sb,
                    a < b, a <= b, a >= b, a > b};
    end else begin
      exp_f[9:0] = {n ^ v, z | (n ^ v), z, !z, !(n ^ v), !(z | (n ^ v)),
                    !c, !c | z, c, c & !z};
    end
    if (sat && v)  rtag = (ex > maxv) ? "R9" : "R10";
    else if (sat)  rtag = "R11";
    else           rtag = sub ? "R2" : "R1";
    n_vec++;
    if (got_r != exp_r) begin
      n_fail++;
      $display("FAIL %s result N=%0d a=%0h b=%0h sub=%0d sat=%0d got=%0h exp=%0h",
               rtag, w, a, b, sub, sat, got_r, exp_r);
    end
    for (int i = 0; i < 14; i++) begin
      if (got_f[i] !== exp_f[i]) begin
        case (i)
          13: ftag = "R3";
          12: ftag = "R4";
          11: ftag = "R5";
          10: ftag = "R6";
          default: ftag = (i >= 4) ? "R7" : "R8";
        endcase
        if (sat) ftag = {ftag, " R12"};
        n_fail++;
        $display("FAIL %s flag %s N=%0d a=%0h b=%0h sub=%0d sat=%0d got=%0b exp=%0b",
                 ftag, names[i], w, a, b, sub, sat, got_f[i], exp_f[i]);
      end
    end
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b,
                       input bit sub, input bit sat);
    a32 = a; b32 = b; s32 = sub; t32 = sat;
    #0.5;
    judge(32, a, b, sub, sat, r32, f32);
    #0.5;
  endtask

  initial begin
    a4 = '0; b4 = '0; s4 = 1'b0; t4 = 1'b0;
    a8 = '0; b8 = '0; s8 = 1'b0; t8 = 1'b0;
    a32 = '0; b32 = '0; s32 = 1'b0; t32 = 1'b0;
    #2;
    // Idle state: zero operands give zero result, Z set (R1, R3)
    judge(4, 0, 0, 0, 0, r4, f4);
    // N=4 full sweep: includes 0111+0111 and the most negative value
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          a4 = a[3:0]; b4 = b[3:0]; s4 = op[0]; t4 = op[1];
          #0.5;
          judge(4, a, b, op[0], op[1], r4, f4);
          #0.5;
        end
      end
    end
    // N=8 full sweep
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          a8 = a[7:0]; b8 = b[7:0]; s8 = op[0]; t8 = op[1];
          #0.5;
          judge(8, a, b, op[0], op[1], r8, f8);
          #0.5;
        end
      end
    end
    // N=32 corners (R9, R10, R5, R6 at full width)
    for (int op = 0; op < 4; op++) begin
      run32(32'h7FFF_FFFF, 32'h0000_0001, op[0], op[1]);
      run32(32'h8000_0000, 32'h0000_0001, op[0], op[1]);
      run32(32'h8000_0000, 32'h8000_0000, op[0], op[1]);
      run32(32'hFFFF_FFFF, 32'h0000_0001, op[0], op[1]);
      run32(32'h0000_0000, 32'h8000_0000, op[0], op[1]);
      run32(32'h1234_5678, 32'h1234_5678, op[0], op[1]);
      run32(32'h7FFF_FFFF, 32'hFFFF_FFFF, op[0], op[1]);
      run32(32'hDEAD_BEEF, 32'h0BAD_F00D, op[0], op[1]);
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got=%0d cycles exp<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule